// File: doc/BRIEF.md
# LIN Break and Sync Bit-Rate Detector

This block listens to the already synchronised receive line of a LIN responder node and works out the bit rate the commander is using. It times the dominant break with one free-running capture timer. The timer value is latched on a falling edge of the line and again on the following rising edge. The detector checks that the break is long enough. It then watches the sync byte (0x55). On the wire this byte is a regular train of alternating bits, so its falling edges are spaced two bit times apart. The detector measures eight bit times across that train and divides by eight. The result is the bit period for the downstream receiver, in clock cycles.

The detector does nothing after reset until software or a frame handler pulses `restart`. After a successful measurement it raises `sync_done` for one cycle and then goes quiet until the next `restart`. Once a break has begun, a separate watchdog counter guards the search. If the line stops moving for too long, the detector raises `sync_error` for one cycle and arms itself again without outside help.

Top module: `lin_sync_detect`

## Requirements
- R1: After reset `break_len` and `bit_period` are 0, `sync_done` and `sync_error` are low, and edges on `rx` have no effect until the first `restart` pulse.
- R2: A one-cycle `restart` pulse, sampled at a clock edge, is followed by one arming cycle. After that cycle a falling edge of `rx` (high in the previous cycle, low in this one) is taken as the start of a break.
- R3: The break length is the number of clock cycles from the cycle of the break's falling edge to the cycle of its rising edge. A break of at least `MIN_BREAK` cycles (default 11 × 16 = 176) is accepted, and `break_len` shows the new length from the cycle after the rising edge.
- R4: A break shorter than `MIN_BREAK` is dropped. `break_len` keeps its old value, no pulse is raised, and the detector waits for a new break.
- R5: After an accepted break, the next falling edge marks the sync start. On the fourth falling edge after it, `bit_period` becomes the cycle count between those two edges shifted right by 3 (truncated). `sync_done` is high for exactly the one cycle after that edge, and `bit_period` takes its new value in that same cycle.
- R6: After `sync_done` the detector is idle. Further `rx` activity changes no output until the next `restart`.
- R7: Between the break's falling edge and the end of the sync measurement, if `TIMEOUT` consecutive cycles (default 2000) pass with no edge on `rx`, `sync_error` is high for one cycle starting the cycle after the last of them. The detector then re-arms by itself (one idle cycle, one arming cycle) and looks for a new break.
- R8: Time differences are taken modulo 2^`TW`. A break or sync span that crosses the timer's wrap from all-ones to zero is measured correctly.
- R9: `restart` takes priority in every state. A measurement under way is abandoned without `sync_done` or `sync_error`, and a new search begins.
- R10: `sync_done` and `sync_error` are never high together, and neither stays high for two consecutive cycles.
- R11: While the detector waits for a break, no timeout applies. An idle bus produces no `sync_error`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx | input | 1 | Synchronised LIN receive line (1 = recessive) |
| restart | input | 1 | Single-cycle strobe that starts or restarts the search |
| break_len | output | TW | Length of the last accepted break, in cycles |
| bit_period | output | TW | Measured bit period, in cycles |
| sync_done | output | 1 | One-cycle pulse when a new bit period is available |
| sync_error | output | 1 | One-cycle pulse when the search timed out |

## Verification
The checker watches several properties on every cycle. The two result pulses must stay exclusive and one cycle long. Any change of `break_len` must be a length of at least `MIN_BREAK`. Any change of `bit_period` must come with `sync_done`. Every `sync_error` must be caused by an expired watchdog that `restart` did not override, and a `restart` must be followed by a quiet cycle. The numeric results can only be shown by the bench scenarios, because they depend on the edge timing the bench drives. These scenarios cover exact break and period values, truncation of the divide, rejection of short breaks, the idle state after a success, watchdog recovery in two different waiting phases, silence on an idle bus, abandonment by `restart`, and a measurement that crosses the timer wrap.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_ARM,
      ST_WAIT_DOM,
      ST_WAIT_REC,
      ST_WAIT_SYNC,
      ST_MEAS,
      ST_DONE,
      ST_FAIL
   } lsd_state_e;

   // 0x55 sent LSB first after a start bit: falling edges every two bits
   localparam int LSD_SPAN_BITS  = 8;
   localparam int LSD_SPAN_SHIFT = 3;
   localparam int LSD_TAIL_FALLS = 4;
   localparam int LSD_FCNT_W     = 3;

endpackage

// File: rtl/lsd_edge.sv
module lsd_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic rx,
   output logic fall,
   output logic rise
);
   logic rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_q <= 1'b1;
      else        rx_q <= rx;
   end

   assign fall = rx_q & ~rx;
   assign rise = ~rx_q & rx;
endmodule

// File: rtl/lsd_free_timer.sv
module lsd_free_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [TW-1:0] now
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now <= '0;
      else        now <= now + 1'b1;
   end
endmodule

// File: rtl/lsd_timeout.sv
module lsd_timeout #(
   parameter int TOW     = 16,
   parameter int TIMEOUT = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic kick,
   output logic expired
);
   localparam logic [TOW-1:0] RELOAD = TOW'(TIMEOUT - 1);

   logic [TOW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= RELOAD;
      else if (!run || kick)    cnt <= RELOAD;
      else if (cnt != '0)       cnt <= cnt - 1'b1;
   end

   assign expired = run && !kick && (cnt == '0);
endmodule

// File: rtl/lsd_rate_div.sv
module lsd_rate_div #(
   parameter int TW    = 16,
   parameter int SHIFT = 3,
   parameter int ROUND = 0
) (
   input  logic [TW-1:0] span,
   output logic [TW-1:0] period
);
   generate
      if (ROUND != 0) begin : g_round
         localparam logic [TW:0] HALF = (TW+1)'(1) << (SHIFT - 1);
         logic [TW:0] biased;
         assign biased = {1'b0, span} + HALF;
         assign period = TW'(biased >> SHIFT);
      end else begin : g_trunc
         assign period = span >> SHIFT;
      end
   endgenerate
endmodule

// File: rtl/lin_sync_detect.sv
module lin_sync_detect
   import lsd_pkg::*;
#(
   parameter int TW        = 16,
   parameter int TOW       = 16,
   parameter int SLOW_BIT  = 16,
   parameter int TIMEOUT   = 2000,
   parameter int ROUND     = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx,
   input  logic          restart,
   output logic [TW-1:0] break_len,
   output logic [TW-1:0] bit_period,
   output logic          sync_done,
   output logic          sync_error
);
   localparam int MIN_BREAK = 11 * SLOW_BIT;
   localparam logic [TW-1:0] MIN_BRK_V = TW'(MIN_BREAK);
   localparam logic [LSD_FCNT_W-1:0] LAST_FALL = LSD_FCNT_W'(LSD_TAIL_FALLS - 1);

   generate
      if (TW < 8) begin : g_bad_tw
         $error("lin_sync_detect: TW must be at least 8");
      end
      if (MIN_BREAK >= (2 ** TW)) begin : g_bad_brk
         $error("lin_sync_detect: minimum break does not fit the timer");
      end
      if (TIMEOUT < 2 || TIMEOUT > (2 ** TOW)) begin : g_bad_to
         $error("lin_sync_detect: TIMEOUT out of range for TOW");
      end
      if (ROUND != 0 && ROUND != 1) begin : g_bad_round
         $error("lin_sync_detect: ROUND must be 0 or 1");
      end
   endgenerate

   logic          fall, rise;
   logic [TW-1:0] tnow, t0, elapsed, period_w;
   logic          to_run, to_expired;
   logic [LSD_FCNT_W-1:0] fcnt;
   lsd_state_e    state;

   lsd_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .rx    (rx),
      .fall  (fall),
      .rise  (rise)
   );

   lsd_free_timer #(.TW(TW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .now   (tnow)
   );

   assign to_run = (state == ST_WAIT_REC) || (state == ST_WAIT_SYNC) || (state == ST_MEAS);

   lsd_timeout #(.TOW(TOW), .TIMEOUT(TIMEOUT)) u_timeout (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (to_run),
      .kick    (fall | rise),
      .expired (to_expired)
   );

   assign elapsed = tnow - t0;

   lsd_rate_div #(.TW(TW), .SHIFT(LSD_SPAN_SHIFT), .ROUND(ROUND)) u_div (
      .span   (elapsed),
      .period (period_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_OFF;
         t0         <= '0;
         fcnt       <= '0;
         break_len  <= '0;
         bit_period <= '0;
      end else if (restart) begin
         state <= ST_ARM;
      end else begin
         case (state)
            ST_OFF: state <= ST_OFF;
            ST_ARM: state <= ST_WAIT_DOM;
            ST_WAIT_DOM: begin
               if (fall) begin
                  t0    <= tnow;
                  state <= ST_WAIT_REC;
               end
            end
            ST_WAIT_REC: begin
               if (rise) begin
                  if (elapsed >= MIN_BRK_V) begin
                     break_len <= elapsed;
                     state     <= ST_WAIT_SYNC;
                  end else begin
                     state <= ST_WAIT_DOM;
                  end
               end else if (to_expired) begin
                  state <= ST_FAIL;
               end
            end
            ST_WAIT_SYNC: begin
               if (fall) begin
                  t0    <= tnow;
                  fcnt  <= '0;
                  state <= ST_MEAS;
               end else if (to_expired) begin
                  state <= ST_FAIL;
               end
            end
            ST_MEAS: begin
               if (fall) begin
                  if (fcnt == LAST_FALL) begin
                     bit_period <= period_w;
                     state      <= ST_DONE;
                  end else begin
                     fcnt <= fcnt + 1'b1;
                  end
               end else if (to_expired) begin
                  state <= ST_FAIL;
               end
            end
            ST_DONE: state <= ST_OFF;
            ST_FAIL: state <= ST_ARM;
            default: state <= ST_OFF;
         endcase
      end
   end

   assign sync_done  = (state == ST_DONE);
   assign sync_error = (state == ST_FAIL);
endmodule

// File: rtl/lsd_checker.sv
module lsd_checker #(
   parameter int TW        = 16,
   parameter int MIN_BREAK = 176
) (
   input logic          clk,
   input logic          rst_n,
   input logic          restart,
   input logic          expired,
   input logic [TW-1:0] break_len,
   input logic [TW-1:0] bit_period,
   input logic          sync_done,
   input logic          sync_error
);
   assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(sync_done && sync_error));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sync_done |=> !sync_done);

   assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sync_error |=> !sync_error);

   assert_break_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(break_len) |-> (break_len >= TW'(MIN_BREAK)));

   assert_period_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bit_period) |-> sync_done);

   assert_timeout_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !restart) |=> sync_error);

   assert_error_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_error |-> $past(expired));

   assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!sync_done && !sync_error));
endmodule

bind lin_sync_detect lsd_checker #(.TW(TW), .MIN_BREAK(MIN_BREAK)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .restart    (restart),
   .expired    (to_expired),
   .break_len  (break_len),
   .bit_period (bit_period),
   .sync_done  (sync_done),
   .sync_error (sync_error)
);

// File: tb/lin_sync_detect_tb.sv
`timescale 1ns/1ps
module lin_sync_detect_tb;
   localparam int TW = 16;
   localparam int MINB = 176;
   localparam int TMO = 2000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx = 1'b1;
   logic restart = 1'b0;
   logic [TW-1:0] break_len, bit_period;
   logic sync_done, sync_error;

   always #5 clk = ~clk;

   lin_sync_detect u_dut (
      .clk(clk), .rst_n(rst_n), .rx(rx), .restart(restart),
      .break_len(break_len), .bit_period(bit_period),
      .sync_done(sync_done), .sync_error(sync_error)
   );

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;
   int err_cnt = 0;

   // behavioural reference, phases as plain integers
   int ph = 0;          // 0 off,1 arm,2 dom,3 rec,4 sync,5 meas,6 fail-hold
   int cyc = 0;
   int tstart = 0;
   int gap = 0;
   int nf = 0;
   int prv = 1;
   int e_blen = 0, e_per = 0;
   bit e_done = 0, e_err = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; cyc = 0; prv = 1; e_blen = 0; e_per = 0; e_done = 0; e_err = 0;
      end else begin
         automatic bit f = (prv == 1) && (rx == 1'b0);
         automatic bit r = (prv == 0) && (rx == 1'b1);
         automatic int len;
         cyc++;
         e_done = 0; e_err = 0;
         if (restart) ph = 1;
         else begin
            case (ph)
               1: ph = 2;
               2: if (f) begin tstart = cyc; ph = 3; gap = 0; end
               3: if (r) begin
                     len = cyc - tstart;
                     if (len >= MINB) begin e_blen = len; ph = 4; gap = 0; end
                     else ph = 2;
                  end else if (gap == TMO - 1) begin e_err = 1; ph = 6; end
                  else gap++;
               4: if (f) begin tstart = cyc; nf = 0; ph = 5; gap = 0; end
                  else if (r) gap = 0;
                  else if (gap == TMO - 1) begin e_err = 1; ph = 6; end
                  else gap++;
               5: if (f) begin
                     nf++; gap = 0;
                     if (nf == 4) begin e_per = (cyc - tstart) >> 3; e_done = 1; ph = 0; end
                  end else if (r) gap = 0;
                  else if (gap == TMO - 1) begin e_err = 1; ph = 6; end
                  else gap++;
               6: ph = 1;
               default: ;
            endcase
         end
         prv = rx;
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (break_len !== TW'(e_blen)) begin
            errors++; $display("FAIL R3 break_len act=%0d exp=%0d t=%0t", break_len, e_blen, $time);
         end
         if (bit_period !== TW'(e_per)) begin
            errors++; $display("FAIL R5 bit_period act=%0d exp=%0d t=%0t", bit_period, e_per, $time);
         end
         if (sync_done !== e_done) begin
            errors++; $display("FAIL R5 sync_done act=%0b exp=%0b t=%0t", sync_done, e_done, $time);
         end
         if (sync_error !== e_err) begin
            errors++; $display("FAIL R7 sync_error act=%0b exp=%0b t=%0t", sync_error, e_err, $time);
         end
         if (sync_done === 1'b1) done_cnt++;
         if (sync_error === 1'b1) err_cnt++;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int n);
      rx = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic kick();
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      hold(1'b1, 4);
   endtask

   task automatic frame(input int brk, input int t, input int extra);
      hold(1'b0, brk);
      hold(1'b1, t);
      hold(1'b0, t);            // start bit
      hold(1'b1, t + extra);    // data bit 0
      for (int i = 1; i < 8; i++) hold(((i % 2) == 0) ? 1'b1 : 1'b0, t);
      hold(1'b1, t);            // stop bit
      hold(1'b1, 3 * t);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values and inactivity before restart
      chk("R1 break_len after reset", break_len, 0);
      chk("R1 bit_period after reset", bit_period, 0);
      chk("R1 pulses after reset", {sync_done, sync_error}, 0);
      frame(260, 20, 0);
      chk("R1 no detection before restart", done_cnt, 0);
      chk("R1 break_len untouched", break_len, 0);

      // R2 R3 R5: nominal frame
      kick();
      frame(260, 20, 0);
      chk("R3 break length", break_len, 260);
      chk("R5 period", bit_period, 20);
      chk("R2 R5 one done pulse", done_cnt, 1);

      // R6: ignored after success
      frame(300, 25, 0);
      chk("R6 break_len held", break_len, 260);
      chk("R6 period held", bit_period, 20);
      chk("R6 no extra done", done_cnt, 1);

      // R4: short break dropped
      kick();
      hold(1'b0, 100);
      hold(1'b1, 50);
      chk("R4 short break ignored", break_len, 260);
      chk("R4 no pulse", done_cnt + err_cnt, 1);
      frame(300, 23, 0);
      chk("R4 next break accepted", break_len, 300);
      chk("R4 period after short break", bit_period, 23);

      // R5: truncation of uneven span (8*21+7 = 175 -> 21)
      kick();
      frame(250, 21, 7);
      chk("R5 truncated period", bit_period, 21);
      chk("R5 done count", done_cnt, 3);

      // R7: timeout while line stuck dominant, then automatic re-arm
      kick();
      hold(1'b0, 2100);
      chk("R7 error on stuck break", err_cnt, 1);
      hold(1'b1, 40);
      frame(260, 22, 0);
      chk("R7 recovery done", done_cnt, 4);
      chk("R7 recovery period", bit_period, 22);

      // R7: timeout waiting for sync start
      kick();
      hold(1'b0, 260);
      hold(1'b1, 2100);
      chk("R7 error waiting for sync", err_cnt, 2);

      // R11: idle bus while waiting for break
      kick();
      hold(1'b1, 3000);
      chk("R11 idle no error", err_cnt, 2);

      // R9: restart abandons measurement
      kick();
      hold(1'b0, 270);
      hold(1'b1, 20);
      hold(1'b0, 20);
      hold(1'b1, 20);
      kick();
      chk("R9 no done after abandon", done_cnt, 4);
      chk("R9 no error after abandon", err_cnt, 2);
      frame(280, 24, 0);
      chk("R9 new search period", bit_period, 24);

      // R8: measurement across timer wrap
      while (cyc < 65400) @(negedge clk);
      kick();
      while (cyc < 65450) @(negedge clk);
      frame(300, 26, 0);
      chk("R8 wrap break length", break_len, 300);
      chk("R8 wrap period", bit_period, 26);
      chk("R10 total errors seen", err_cnt, 2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule